// File: doc/BRIEF.md
# Slave TDM Serial Audio Receiver

This block is a clock-slave serial audio input port. An external master supplies a bit clock and a frame clock. Up to `LANES` serial data pins share those two clocks. Each pin has its own capture path, so several independent two-channel streams can be received side by side. The port is configured for a nominal frame of `SLOTS` slots, each `SLOT_W` bits wide. All three inputs are oversampled in a faster system clock domain through multi-flop synchronizers, and edges are detected in that domain. The system clock must run at least four times faster than the bit clock.

A frame is closed by the chosen frame clock edge, not by a bit counter. If the master delivers fewer bits than the nominal frame holds, the bits received so far are committed at that edge. Any slot that received no bits reads as zero. A typical case is a 64-bit two-channel stream arriving at a port set up for four 32-bit slots: slots 0 and 1 carry the two channels and slots 2 and 3 are zero. If the master delivers more bits than the frame holds, the excess is dropped and an overflow flag marks that frame. Each committed frame appears on a wide parallel output together with a one-cycle strobe.

Top module: `tdm_slave_rx`

## Requirements
- R1: While `rst_n` is low, and after reset until the first committed frame, `frame_valid` is 0, `frame_ovf` is 0 and every bit of `slot_words` is 0.
- R2: After reset the receiver waits for the first frame edge. Bits that arrive before and at that edge are discarded, and that edge produces no `frame_valid` pulse.
- R3: With `FRAME_EDGE` = EDGE_FALL (the default), a frame ends at the bit clock rising edge where the sampled frame clock is 0 and it was 1 at the previous rising edge. EDGE_RISE selects the opposite polarity. The bit sampled at that rising edge is the last bit of the ending frame, and the next rising edge samples position 0 of the new frame (a one-bit delay in the I2S manner). An edge of the opposite polarity does not end a frame. Each frame produces exactly one pulse.
- R4: Data is sampled on bit clock rising edges, MSB first. Frame position p goes to slot p/32, bit 31-(p mod 32). Lane l, slot s is found at `slot_words[(l*SLOTS+s)*32 +: 32]`.
- R5: A frame of exactly 128 bits fills all four slots of every lane.
- R6: A short frame (fewer than 128 bits) places its bits at positions 0 up to N-1, unchanged. With 64 bits, slots 0 and 1 hold the two received words intact.
- R7: Each lane captures only its own data pin. Activity on one pin does not change the words of any other lane.
- R8: `frame_valid` is high for exactly one system clock per committed frame. `slot_words` and `frame_ovf` are already valid in that cycle.
- R9: Bits beyond position 127 in a frame are discarded, and `frame_ovf` is 1 for that frame. For a frame of 128 bits or fewer, `frame_ovf` is 0.
- R10: `slot_words` and `frame_ovf` hold their values between commits.
- R11: Bit positions that receive no bit in a frame read as 0, even when the previous frame had filled them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | External bit clock |
| fclk | input | 1 | External frame clock |
| sdata | input | LANES | Serial data pins, one per lane |
| slot_words | output | LANES*SLOTS*SLOT_W | Committed slot words, lane-major then slot |
| frame_valid | output | 1 | One-cycle strobe for a newly committed frame |
| frame_ovf | output | 1 | The last committed frame received more bits than the frame holds |

## Verification
Frames are sent at 128, 160, 96, 100, 64 and 32 bits, and the bench compares every slot of every lane. The 128-bit frames show that all four slots fill with the one-bit delay and the slot order from R4. The 64-bit and 32-bit frames show that a short frame commits at the frame clock edge and that unfilled slots are cleared rather than left stale from an earlier full frame. The 96-bit and 100-bit lengths show the cases where the frame edge falls on a slot boundary and in the middle of a slot. The 160-bit frame exercises the discarded tail and the overflow flag. A directed single-bit frame pins down the bit order, and a frame driven on one lane only shows that lanes are independent. A preamble sent before lock shows that the first partial frame after reset is dropped.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

   // Which frame clock transition closes a frame.
   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } frame_edge_e;

   // Synchronizer depth that the clock-ratio rule assumes.
   localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/tdm_rx_sync.sv
module tdm_rx_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] d_out
);

   localparam int unsigned CW = STAGES * W;

   initial begin
      assert (STAGES >= tdm_rx_pkg::MIN_SYNC_STAGES)
         else $error("tdm_rx_sync: STAGES below the minimum");
      assert (W >= 1) else $error("tdm_rx_sync: W must be at least 1");
   end

   // All bits move through the same number of stages, so they stay aligned in time.
   logic [CW-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[CW-W-1:0], d_in};
   end

   assign d_out = chain_q[CW-1 -: W];

endmodule

// File: rtl/tdm_rx_frame_ctl.sv
module tdm_rx_frame_ctl #(
   parameter int unsigned               FRAME_BITS = 128,
   parameter tdm_rx_pkg::frame_edge_e   FRAME_EDGE = tdm_rx_pkg::EDGE_FALL,
   localparam int unsigned              PW         = $clog2(FRAME_BITS + 1),
   localparam int unsigned              IW         = $clog2(FRAME_BITS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bclk_s,
   input  logic          fclk_s,
   output logic          wr_en,
   output logic [IW-1:0] wr_idx,
   output logic          commit,
   output logic          frame_valid,
   output logic          frame_ovf
);

   localparam logic [PW-1:0] FULL      = PW'(FRAME_BITS);
   localparam logic          FCLK_IDLE = (FRAME_EDGE == tdm_rx_pkg::EDGE_FALL) ? 1'b0 : 1'b1;

   initial begin
      assert (FRAME_BITS >= 8) else $error("tdm_rx_frame_ctl: FRAME_BITS too small");
   end

   logic          bclk_d;
   logic          fclk_last;
   logic [PW-1:0] pos_q;
   logic          locked_q;
   logic          ovf_acc_q;
   logic          pend_q;
   logic          valid_q;
   logic          ovf_q;
   logic          bit_stb;
   logic          edge_hit;
   logic          boundary;

   assign bit_stb = bclk_s & ~bclk_d;

   // The parameter picks which frame clock transition closes a frame.
   generate
      if (FRAME_EDGE == tdm_rx_pkg::EDGE_FALL) begin : g_fall
         assign edge_hit = fclk_last & ~fclk_s;
      end else begin : g_rise
         assign edge_hit = ~fclk_last & fclk_s;
      end
   endgenerate

   assign boundary = bit_stb & edge_hit;
   assign wr_en    = bit_stb & locked_q & (pos_q < FULL);
   assign wr_idx   = pos_q[IW-1:0];
   assign commit   = pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_d    <= 1'b0;
         fclk_last <= FCLK_IDLE;
         pos_q     <= '0;
         locked_q  <= 1'b0;
         ovf_acc_q <= 1'b0;
         pend_q    <= 1'b0;
         valid_q   <= 1'b0;
         ovf_q     <= 1'b0;
      end else begin
         bclk_d  <= bclk_s;
         pend_q  <= boundary;
         valid_q <= 1'b0;
         if (bit_stb) fclk_last <= fclk_s;
         if (pend_q) begin
            // Close the frame: the count restarts and the flag moves to the output.
            pos_q     <= '0;
            ovf_acc_q <= 1'b0;
            locked_q  <= 1'b1;
            if (locked_q) begin
               valid_q <= 1'b1;
               ovf_q   <= ovf_acc_q;
            end
         end else if (bit_stb && locked_q) begin
            if (pos_q < FULL) pos_q     <= pos_q + 1'b1;
            else              ovf_acc_q <= 1'b1;
         end
      end
   end

   assign frame_valid = valid_q;
   assign frame_ovf   = ovf_q;

   // R8: the strobe never lasts two cycles.
   p_valid_one_cycle_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |=> !frame_valid);

   // R3: each strobe is traced back to a frame edge two cycles earlier.
   p_valid_after_edge_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |-> $past(boundary, 2));

   // R2: no strobe for the edge that establishes lock.
   p_no_valid_unlocked_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |-> $past(locked_q));

   // R9: the position never runs past the end of the frame.
   p_pos_bounded_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      pos_q <= FULL);

   // R9: overflow is only raised once the frame is already full.
   p_ovf_after_full_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_acc_q) |-> ($past(pos_q) == FULL));

   // R3: a commit never coincides with a bit strobe (clock ratio rule).
   p_commit_no_strobe_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> !bit_stb);

endmodule

// File: rtl/tdm_rx_lane.sv
module tdm_rx_lane #(
   parameter int unsigned SLOTS  = 4,
   parameter int unsigned SLOT_W = 32,
   localparam int unsigned FRAME_BITS = SLOTS * SLOT_W,
   localparam int unsigned IW         = $clog2(FRAME_BITS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bit_in,
   input  logic                  wr_en,
   input  logic [IW-1:0]         wr_idx,
   input  logic                  commit,
   output logic [FRAME_BITS-1:0] words
);

   // Bits are stored by arrival position: index p holds frame position p.
   logic [FRAME_BITS-1:0] pos_q;
   logic [FRAME_BITS-1:0] slot_view;
   logic [FRAME_BITS-1:0] words_q;

   // Slot s, bit b comes from position s*SLOT_W + SLOT_W-1-b (MSB arrives first).
   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
         for (genvar b = 0; b < SLOT_W; b++) begin : g_bit
            assign slot_view[s*SLOT_W + b] = pos_q[s*SLOT_W + SLOT_W - 1 - b];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q   <= '0;
         words_q <= '0;
      end else if (commit) begin
         words_q <= slot_view;
         pos_q   <= '0;
      end else if (wr_en) begin
         pos_q[wr_idx] <= bit_in;
      end
   end

   assign words = words_q;

   // R10: the committed words only change at a commit.
   p_words_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(words));

   // R11: the capture buffer is empty right after a commit.
   p_buffer_cleared_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (pos_q == '0));

endmodule

// File: rtl/tdm_slave_rx.sv
module tdm_slave_rx #(
   parameter int unsigned             LANES       = 4,
   parameter int unsigned             SLOTS       = 4,
   parameter int unsigned             SLOT_W      = 32,
   parameter int unsigned             SYNC_STAGES = 2,
   parameter tdm_rx_pkg::frame_edge_e FRAME_EDGE  = tdm_rx_pkg::EDGE_FALL
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            bclk,
   input  logic                            fclk,
   input  logic [LANES-1:0]                sdata,
   output logic [LANES*SLOTS*SLOT_W-1:0]   slot_words,
   output logic                            frame_valid,
   output logic                            frame_ovf
);

   localparam int unsigned FRAME_BITS = SLOTS * SLOT_W;
   localparam int unsigned IW         = $clog2(FRAME_BITS);
   localparam int unsigned SW         = LANES + 2;

   initial begin
      assert (LANES >= 1 && LANES <= 8) else $error("tdm_slave_rx: LANES out of range");
      assert (SLOTS >= 1 && SLOTS <= 16) else $error("tdm_slave_rx: SLOTS out of range");
      assert (SLOT_W >= 8 && SLOT_W <= 32) else $error("tdm_slave_rx: SLOT_W out of range");
   end

   logic [SW-1:0]    raw_in;
   logic [SW-1:0]    sync_out;
   logic             bclk_s;
   logic             fclk_s;
   logic [LANES-1:0] sdata_s;
   logic             wr_en;
   logic [IW-1:0]    wr_idx;
   logic             commit;

   // Clocks and data go through one synchronizer so they keep the same latency.
   assign raw_in = {sdata, fclk, bclk};

   tdm_rx_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (raw_in),
      .d_out (sync_out)
   );

   assign bclk_s  = sync_out[0];
   assign fclk_s  = sync_out[1];
   assign sdata_s = sync_out[SW-1:2];

   tdm_rx_frame_ctl #(.FRAME_BITS(FRAME_BITS), .FRAME_EDGE(FRAME_EDGE)) u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .bclk_s      (bclk_s),
      .fclk_s      (fclk_s),
      .wr_en       (wr_en),
      .wr_idx      (wr_idx),
      .commit      (commit),
      .frame_valid (frame_valid),
      .frame_ovf   (frame_ovf)
   );

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         tdm_rx_lane #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .bit_in (sdata_s[l]),
            .wr_en  (wr_en),
            .wr_idx (wr_idx),
            .commit (commit),
            .words  (slot_words[l*FRAME_BITS +: FRAME_BITS])
         );
      end
   endgenerate

   // R1: outputs stay cleared until a strobe has occurred.
   p_quiet_before_valid_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_ovf) |-> frame_valid);

endmodule

// File: tb/test_tdm_slave_rx.sv
`timescale 1ns/1ps
module test_tdm_slave_rx;

   localparam int LANES  = 4;
   localparam int SLOTS  = 4;
   localparam int SLOT_W = 32;
   localparam int FB     = SLOTS * SLOT_W;
   localparam int TW     = LANES * FB;
   localparam int NVEC   = 8;

   // Each entry: {frame length in bit clocks, data seed}.
   localparam logic [39:0] VEC [NVEC] = '{
      {8'd128, 32'hA5C3_0F1E},
      {8'd64,  32'h1234_5678},
      {8'd96,  32'h0BAD_F00D},
      {8'd160, 32'h5A5A_A5A5},
      {8'd64,  32'hC001_D00D},
      {8'd128, 32'h0000_0000},
      {8'd100, 32'h7E57_1DEA},
      {8'd32,  32'hFFFF_FFFF}
   };

   logic             clk = 1'b0;
   logic             rst_n;
   logic             bclk;
   logic             fclk;
   logic [LANES-1:0] sdata;
   logic [TW-1:0]    slot_words;
   logic             frame_valid;
   logic             frame_ovf;

   int checks = 0;
   int errors = 0;
   int n_valid = 0;
   int wide_pulse = 0;
   logic valid_prev = 1'b0;
   logic [TW-1:0] cap_words = '0;
   logic cap_ovf = 1'b0;

   always #2.5 clk = ~clk;

   tdm_slave_rx i_tdm_slave_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .bclk        (bclk),
      .fclk        (fclk),
      .sdata       (sdata),
      .slot_words  (slot_words),
      .frame_valid (frame_valid),
      .frame_ovf   (frame_ovf)
   );

   // Sample outputs on the falling system clock edge, away from the active edge.
   always @(negedge clk) begin
      if (frame_valid) begin
         n_valid++;
         cap_words = slot_words;
         cap_ovf   = frame_ovf;
         if (valid_prev) wide_pulse++;
      end
      valid_prev = frame_valid;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] word_of(input logic [31:0] seed, input int lane, input int slot);
      return seed ^ (32'h9E37_79B9 * (lane * SLOTS + slot + 1));
   endfunction

   // mode 0: seeded words; mode 1: single 1 at position 33 on lane 0
   function automatic logic bit_of(input int mode, input logic [31:0] seed, input logic [LANES-1:0] mask,
                                   input int lane, input int p);
      logic [31:0] w;
      if (!mask[lane]) return 1'b0;
      if (mode == 1) return (lane == 0 && p == 33);
      if (p >= FB) return 1'b1;
      w = word_of(seed, lane, p / SLOT_W);
      return w[SLOT_W - 1 - (p % SLOT_W)];
   endfunction

   function automatic logic [31:0] exp_word(input logic [31:0] seed, input int n, input logic [LANES-1:0] mask,
                                            input int lane, input int slot);
      logic [31:0] e;
      logic [31:0] w;
      w = word_of(seed, lane, slot);
      for (int b = 0; b < SLOT_W; b++) begin
         int p;
         p = slot * SLOT_W + SLOT_W - 1 - b;
         e[b] = (mask[lane] && p < n) ? w[b] : 1'b0;
      end
      return e;
   endfunction

   task automatic send_bit(input logic f, input logic [LANES-1:0] d);
      bclk  = 1'b0;
      fclk  = f;
      sdata = d;
      #20;
      bclk = 1'b1;
      #20;
   endtask

   // Frame clock: low, then high for the second half; it falls on the last bit (one-bit delay).
   task automatic send_frame(input int n, input int mode, input logic [31:0] seed, input logic [LANES-1:0] mask);
      for (int j = 0; j < n; j++) begin
         logic f;
         logic [LANES-1:0] d;
         f = (j >= n / 2 - 1) && (j <= n - 2);
         for (int l = 0; l < LANES; l++) d[l] = bit_of(mode, seed, mask, l, j);
         send_bit(f, d);
      end
      bclk = 1'b0;
      #150;
   endtask

   task automatic check_frame(input int n, input logic [31:0] seed, input logic [LANES-1:0] mask, input int nv0);
      chk("R3 one strobe per frame", 32'(n_valid), 32'(nv0 + 1));
      for (int l = 0; l < LANES; l++) begin
         for (int s = 0; s < SLOTS; s++) begin
            string tag;
            if (!mask[l])             tag = "R7 idle lane";
            else if (s * SLOT_W >= n) tag = "R11 unfilled slot";
            else if (n > FB)          tag = "R9 overflow frame slot";
            else if (n == FB)         tag = "R5 full frame slot";
            else                      tag = "R6 short frame slot";
            chk(tag, cap_words[(l*SLOTS+s)*SLOT_W +: SLOT_W], exp_word(seed, n, mask, l, s));
         end
      end
      chk("R9 overflow flag", 32'(cap_ovf), 32'(n > FB));
      #150;
      chk("R10 words held", 32'(slot_words == cap_words), 32'd1);
   endtask

   initial begin
      #400_000;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int nv0;
      rst_n = 1'b0;
      bclk  = 1'b0;
      fclk  = 1'b0;
      sdata = '0;
      repeat (5) @(posedge clk);
      #1;
      chk("R1 reset valid", 32'(frame_valid), 32'd0);
      chk("R1 reset ovf", 32'(frame_ovf), 32'd0);
      chk("R1 reset words", 32'(slot_words == '0), 32'd1);
      rst_n = 1'b1;
      #50;

      // Preamble: ones on all pins, then the locking edge.
      for (int j = 0; j < 10; j++) send_bit(1'b1, '1);
      send_bit(1'b0, '1);
      bclk = 1'b0;
      #150;
      chk("R2 no strobe on lock", 32'(n_valid), 32'd0);
      chk("R2 preamble discarded", 32'(slot_words == '0), 32'd1);

      for (int v = 0; v < NVEC; v++) begin
         int n;
         logic [31:0] seed;
         n    = int'(VEC[v][39:32]);
         seed = VEC[v][31:0];
         nv0  = n_valid;
         send_frame(n, 0, seed, '1);
         check_frame(n, seed, '1, nv0);
      end

      // R4: a single 1 at frame position 33 on lane 0 lands in slot 1, bit 30.
      nv0 = n_valid;
      send_frame(FB, 1, 32'h0, '1);
      chk("R4 strobe", 32'(n_valid), 32'(nv0 + 1));
      chk("R4 slot0", cap_words[0 +: 32], 32'h0000_0000);
      chk("R4 slot1", cap_words[32 +: 32], 32'h4000_0000);

      // R7: only lane 2 carries data.
      nv0 = n_valid;
      send_frame(FB, 0, 32'h3C3C_9696, 4'b0100);
      check_frame(FB, 32'h3C3C_9696, 4'b0100, nv0);

      chk("R8 strobe width", 32'(wide_pulse), 32'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule